// File: doc/BRIEF.md
# Fine-Grained Label Egress Filter

This block sits after decapsulation on the egress side of a switch that carries 24-bit tenant labels. Each cycle it may take one frame descriptor. The descriptor holds the 24-bit label, the priority and drop-eligible bit from the low label word, a multi-destination flag, the header multicast bit, and two port bitmaps supplied by an external address lookup: ports known to reach the inner destination MAC, and ports known not to reach it. For every output port it decides whether the frame may leave there. For each selected port it also supplies the outgoing C-VLAN ID, whether a tag is to be written, and the priority bits.

Each port has a small content-addressable table of label entries. An entry holds a valid bit, a full 24-bit label and the C-VLAN ID used when that label leaves the port. A port may only emit a frame whose complete label appears in one of its valid entries. Sharing only the upper 12 bits with a configured label is never enough. A per-port strip option sends frames out untagged. Entries are written through a single configuration write port. While a write is in progress the descriptor input is held off.

Top module: `fgl_egress_filter`

## Requirements
- R1: A port is selected only if one of its valid entries holds the frame's exact 24-bit label. An entry equal only in bits 23:12 does not qualify.
- R2: A multi-destination descriptor (`in_multi`=1) selects every port holding the label, whatever the lookup bitmaps say.
- R3: For a unicast descriptor, if `in_known_ports` ANDed with the label-holding ports is non-zero, exactly those ports are selected.
- R4: For a unicast descriptor with no such overlap, the label-holding ports are selected, minus the ports set in `in_excl_ports`.
- R5: For each selected port p, `out_vid[12p+11:12p]` holds the C-VLAN ID of the lowest-index entry of port p matching the label. It is 0 for unselected ports.
- R6: `out_pri` and `out_dei` repeat the descriptor's `in_pri` and `in_dei`.
- R7: `out_tagged[p]` is 1 exactly when port p is selected and `cfg_strip[p]` (sampled with the descriptor) is 0.
- R8: `out_no_forward` is 1 for a valid result exactly when the descriptor was multi-destination with `in_mbit`=0.
- R9: A descriptor accepted at a clock edge (`in_valid` and `in_ready`) gives `out_valid`=1 at the second following edge. Back-to-back descriptors give back-to-back results.
- R10: `in_ready` is 0 while `cfg_we` is 1. A descriptor presented then is dropped and produces no `out_valid`.
- R11: Reset clears every entry and `out_valid`. A write with `cfg_valid`=0 removes that entry's label from its port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_port | input | 2 | Port whose table is written |
| cfg_entry | input | 2 | Entry index within that table |
| cfg_valid | input | 1 | Valid bit written to the entry |
| cfg_label | input | 24 | Label written to the entry |
| cfg_vid | input | 12 | C-VLAN ID written to the entry |
| cfg_strip | input | 4 | Per-port tag strip option |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted when high |
| in_label | input | 24 | Frame label, high part in bits 23:12 |
| in_pri | input | 3 | Priority from the low label word |
| in_dei | input | 1 | Drop-eligible bit from the low label word |
| in_multi | input | 1 | Multi-destination frame |
| in_mbit | input | 1 | Multicast bit of the transport header |
| in_known_ports | input | 4 | Ports the lookup found for the destination MAC |
| in_excl_ports | input | 4 | Ports known not to reach the destination MAC |
| out_valid | output | 1 | Result valid |
| out_ports | output | 4 | Selected egress ports |
| out_tagged | output | 4 | Per-port tag-write flag |
| out_vid | output | 48 | Per-port C-VLAN ID, 12 bits per port |
| out_pri | output | 3 | Output priority |
| out_dei | output | 1 | Output drop-eligible bit |
| out_no_forward | output | 1 | Local egress only, never forward onward |

## Verification
The case hardest to reach from the ports is two labels that share the high 12 bits, held by overlapping sets of ports. Such a port holds the sibling label but not the frame's label, so it looks like a member of VLAN X without being a member of (X.Y). The configuration therefore loads sibling labels, duplicate entries and a label shared by three ports. The bench then sweeps every pair of known and excluded bitmaps under every multi and M-bit combination, so the unicast fallback is exercised for each possible overlap with the label-holding set. Clearing an entry and overlapping a configuration write with a descriptor cover the removal and hold-off paths.

// File: rtl/fgl_pkg.sv
package fgl_pkg;

    localparam int LABEL_W = 24;
    localparam int VID_W   = 12;
    localparam int PRI_W   = 3;

    typedef logic [LABEL_W-1:0] label_t;
    typedef logic [VID_W-1:0]   vid_t;

    typedef struct packed {
        label_t             label;
        logic [PRI_W-1:0]   pri;
        logic               dei;
        logic               multi;
        logic               mbit;
    } desc_t;

    // Frames that came in as serial unicast may only leave as native frames here.
    function automatic logic local_only(input desc_t d);
        return d.multi && !d.mbit;
    endfunction

endpackage

// File: rtl/fgl_port_cam.sv
module fgl_port_cam
    import fgl_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  label_t           wr_label,
    input  vid_t             wr_vid,
    input  label_t           lk_label,
    output logic             hit,
    output vid_t             hit_vid
);

    logic   [ENTRIES-1:0] ent_v;
    label_t               ent_label [ENTRIES];
    vid_t                 ent_vid   [ENTRIES];
    logic   [ENTRIES-1:0] match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_v[e]     <= 1'b0;
                ent_label[e] <= '0;
                ent_vid[e]   <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                ent_v[e]     <= wr_valid;
                ent_label[e] <= wr_label;
                ent_vid[e]   <= wr_vid;
            end
        end
        // Full-width compare: a shared high part alone is not membership.
        assign match[e] = ent_v[e] && (ent_label[e] == lk_label);
    end

    // Lowest index wins when the same label is entered twice.
    always_comb begin
        hit_vid = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_vid = ent_vid[i];
        end
    end
    assign hit = |match;

    assert_entry_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_valid) |=> !ent_v[$past(wr_idx)]);

endmodule

// File: rtl/fgl_egress_decide.sv
module fgl_egress_decide #(
    parameter int PORTS = 4
) (
    input  logic [PORTS-1:0] hit,
    input  logic [PORTS-1:0] known,
    input  logic [PORTS-1:0] excl,
    input  logic             multi,
    output logic [PORTS-1:0] ports
);

    logic [PORTS-1:0] direct;

    assign direct = known & hit;

    always_comb begin
        if (multi)            ports = hit;            // flood to label holders
        else if (|direct)     ports = direct;         // known destination
        else                  ports = hit & ~excl;    // unknown: flood, minus excluded
    end

endmodule

// File: rtl/fgl_egress_filter.sv
module fgl_egress_filter
    import fgl_pkg::*;
#(
    parameter int PORTS   = 4,
    parameter int ENTRIES = 4,
    localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [PORT_W-1:0]      cfg_port,
    input  logic [IDX_W-1:0]       cfg_entry,
    input  logic                   cfg_valid,
    input  logic [LABEL_W-1:0]     cfg_label,
    input  logic [VID_W-1:0]       cfg_vid,
    input  logic [PORTS-1:0]       cfg_strip,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LABEL_W-1:0]     in_label,
    input  logic [PRI_W-1:0]       in_pri,
    input  logic                   in_dei,
    input  logic                   in_multi,
    input  logic                   in_mbit,
    input  logic [PORTS-1:0]       in_known_ports,
    input  logic [PORTS-1:0]       in_excl_ports,
    output logic                   out_valid,
    output logic [PORTS-1:0]       out_ports,
    output logic [PORTS-1:0]       out_tagged,
    output logic [PORTS*VID_W-1:0] out_vid,
    output logic [PRI_W-1:0]       out_pri,
    output logic                   out_dei,
    output logic                   out_no_forward
);

    desc_t            in_desc;
    logic             accept;
    logic [PORTS-1:0] lk_hit;
    vid_t             lk_vid [PORTS];

    assign in_ready = !cfg_we;
    assign accept   = in_valid && in_ready;
    assign in_desc  = '{label: in_label, pri: in_pri, dei: in_dei,
                        multi: in_multi, mbit: in_mbit};

    for (genvar p = 0; p < PORTS; p++) begin : g_cam
        fgl_port_cam #(.ENTRIES(ENTRIES)) cam_i (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (cfg_we && cfg_port == PORT_W'(p)),
            .wr_idx   (cfg_entry),
            .wr_valid (cfg_valid),
            .wr_label (cfg_label),
            .wr_vid   (cfg_vid),
            .lk_label (in_label),
            .hit      (lk_hit[p]),
            .hit_vid  (lk_vid[p])
        );
    end

    // Stage 1: lookup results
    logic             s1_valid;
    desc_t            s1_desc;
    logic [PORTS-1:0] s1_hit, s1_known, s1_excl, s1_strip;
    vid_t             s1_vid [PORTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_desc  <= '0;
            s1_hit   <= '0;
            s1_known <= '0;
            s1_excl  <= '0;
            s1_strip <= '0;
        end else begin
            s1_valid <= accept;
            s1_desc  <= in_desc;
            s1_hit   <= lk_hit;
            s1_known <= in_known_ports;
            s1_excl  <= in_excl_ports;
            s1_strip <= cfg_strip;
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_s1vid
        always_ff @(posedge clk) begin
            if (rst) s1_vid[p] <= '0;
            else     s1_vid[p] <= lk_vid[p];
        end
    end

    // Stage 2: port decision and tag rewrite
    logic [PORTS-1:0] sel;

    fgl_egress_decide #(.PORTS(PORTS)) decide_i (
        .hit   (s1_hit),
        .known (s1_known),
        .excl  (s1_excl),
        .multi (s1_desc.multi),
        .ports (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_ports      <= '0;
            out_tagged     <= '0;
            out_pri        <= '0;
            out_dei        <= 1'b0;
            out_no_forward <= 1'b0;
        end else begin
            out_valid      <= s1_valid;
            out_ports      <= s1_valid ? sel : '0;
            out_tagged     <= s1_valid ? (sel & ~s1_strip) : '0;
            out_pri        <= s1_desc.pri;
            out_dei        <= s1_desc.dei;
            out_no_forward <= s1_valid && local_only(s1_desc);
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_outvid
        always_ff @(posedge clk) begin
            if (rst)
                out_vid[p*VID_W +: VID_W] <= '0;
            else
                out_vid[p*VID_W +: VID_W] <= (s1_valid && sel[p]) ? s1_vid[p] : '0;
        end
    end

    assert_two_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> ##1 out_valid);

    assert_no_accept_R10: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ##1 !out_valid);

    assert_label_only_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_ports & ~$past(s1_hit)) == '0));

    assert_tag_in_ports_R7: assert property (@(posedge clk) disable iff (rst)
        (out_tagged & ~out_ports) == '0);

    assert_local_only_R8: assert property (@(posedge clk) disable iff (rst)
        out_no_forward |-> out_valid);

endmodule

// File: tb/fgl_egress_filter_tb.sv
module fgl_egress_filter_tb_top;

    localparam int NP = 4;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_port, cfg_entry;
    logic        cfg_valid;
    logic [23:0] cfg_label;
    logic [11:0] cfg_vid;
    logic [3:0]  cfg_strip;
    logic        in_valid, in_ready;
    logic [23:0] in_label;
    logic [2:0]  in_pri;
    logic        in_dei, in_multi, in_mbit;
    logic [3:0]  in_known_ports, in_excl_ports;
    logic        out_valid;
    logic [3:0]  out_ports, out_tagged;
    logic [47:0] out_vid;
    logic [2:0]  out_pri;
    logic        out_dei, out_no_forward;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    fgl_egress_filter #(.PORTS(NP), .ENTRIES(NE)) dut_i (.*);

    // Bench mirror of the configuration
    logic [23:0] m_lbl [NP][NE];
    logic [11:0] m_vid [NP][NE];
    logic        m_v   [NP][NE];

    localparam logic [23:0] LA = 24'h005_001;
    localparam logic [23:0] LB = 24'h005_002;
    localparam logic [23:0] LC = 24'hABC_DEF;
    localparam logic [23:0] LD = 24'h123_456;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int p, input int e, input bit v, input logic [23:0] l,
                      input logic [11:0] vid);
        @(negedge clk);
        cfg_we = 1; cfg_port = 2'(p); cfg_entry = 2'(e);
        cfg_valid = v; cfg_label = l; cfg_vid = vid;
        @(negedge clk);
        cfg_we = 0;
        m_lbl[p][e] = l; m_vid[p][e] = vid; m_v[p][e] = v;
    endtask

    // Expected label holders and their mapped C-VLAN (lowest entry wins)
    function automatic void model(input logic [23:0] l, output logic [3:0] hit,
                                  output logic [47:0] vids);
        hit = '0; vids = '0;
        for (int p = 0; p < NP; p++) begin
            for (int e = NE - 1; e >= 0; e--) begin
                if (m_v[p][e] && m_lbl[p][e] == l) begin
                    hit[p] = 1'b1;
                    vids[p*12 +: 12] = m_vid[p][e];
                end
            end
        end
    endfunction

    task automatic drive(input logic [23:0] l, input logic [2:0] pri, input bit dei,
                         input bit multi, input bit mbit, input logic [3:0] kn,
                         input logic [3:0] ex);
        in_valid = 1; in_label = l; in_pri = pri; in_dei = dei;
        in_multi = multi; in_mbit = mbit; in_known_ports = kn; in_excl_ports = ex;
    endtask

    task automatic check_out(input logic [23:0] l, input logic [2:0] pri, input bit dei,
                             input bit multi, input bit mbit, input logic [3:0] kn,
                             input logic [3:0] ex);
        logic [3:0]  hit, exp_ports, exp_tag;
        logic [47:0] vids, exp_vid;
        string       rq;
        model(l, hit, vids);
        if (multi) begin
            exp_ports = hit; rq = "R2";
        end else if ((kn & hit) != 0) begin
            exp_ports = kn & hit; rq = "R3";
        end else begin
            exp_ports = hit & ~ex; rq = "R4";
        end
        exp_tag = exp_ports & ~cfg_strip;
        exp_vid = '0;
        for (int p = 0; p < NP; p++)
            if (exp_ports[p]) exp_vid[p*12 +: 12] = vids[p*12 +: 12];
        chk(out_valid == 1'b1, "R9 out_valid", int'(out_valid), 1);
        chk(out_ports == exp_ports, rq, int'(out_ports), int'(exp_ports));
        chk(out_vid == exp_vid, "R5 vid", int'(out_vid[31:0]), int'(exp_vid[31:0]));
        chk(out_tagged == exp_tag, "R7 tagged", int'(out_tagged), int'(exp_tag));
        chk(out_pri == pri && out_dei == dei, "R6 pri/dei",
            int'({out_pri, out_dei}), int'({pri, dei}));
        chk(out_no_forward == (multi && !mbit), "R8 no_forward",
            int'(out_no_forward), int'(multi && !mbit));
        if (l == LB) // port 0 holds LA (same high part) but never LB
            chk(out_ports[0] == 1'b0, "R1 sibling label", int'(out_ports[0]), 0);
    endtask

    task automatic one(input logic [23:0] l, input logic [2:0] pri, input bit dei,
                       input bit multi, input bit mbit, input logic [3:0] kn,
                       input logic [3:0] ex);
        @(negedge clk);
        drive(l, pri, dei, multi, mbit, kn, ex);
        @(negedge clk);
        in_valid = 0;
        @(negedge clk);
        check_out(l, pri, dei, multi, mbit, kn, ex);
    endtask

    initial begin
        #2_000_000ns;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] lbls [4];
        logic [23:0] seq  [4];
        lbls = '{LA, LB, LC, LD};
        seq  = '{LC, LA, LB, LA};
        for (int p = 0; p < NP; p++)
            for (int e = 0; e < NE; e++) begin
                m_v[p][e] = 0; m_lbl[p][e] = '0; m_vid[p][e] = '0;
            end
        rst = 1; cfg_we = 0; cfg_port = 0; cfg_entry = 0; cfg_valid = 0;
        cfg_label = 0; cfg_vid = 0; cfg_strip = 4'b0100;
        in_valid = 0; in_label = 0; in_pri = 0; in_dei = 0; in_multi = 0;
        in_mbit = 0; in_known_ports = 0; in_excl_ports = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: reset state
        chk(out_valid == 0, "R11 reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1, "R10 ready idle", int'(in_ready), 1);
        one(LA, 3'd1, 0, 1, 1, 4'h0, 4'h0);   // empty tables: nothing selected (R11)

        // Configuration
        wr(0, 0, 1, LA, 12'd10); wr(0, 1, 1, LC, 12'd20);
        wr(1, 0, 1, LB, 12'd11); wr(1, 2, 1, LA, 12'd12); wr(1, 3, 1, LA, 12'd13);
        wr(2, 1, 1, LC, 12'd30);
        wr(3, 0, 1, LA, 12'd40); wr(3, 1, 1, LB, 12'd41); wr(3, 2, 1, LC, 12'd42);

        // Sweep: labels x known x excluded x (multi, mbit)
        for (int li = 0; li < 4; li++)
            for (int k = 0; k < 16; k++)
                for (int x = 0; x < 16; x++)
                    for (int m = 0; m < 4; m++)
                        one(lbls[li], 3'((k + x + m) % 8), x[0], m[1], m[0], 4'(k), 4'(x));

        // R9: back-to-back descriptors
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) check_out(seq[i-2], 3'(i-2), 1'b0, 1'b1, 1'b1, 4'h0, 4'h0);
            if (i < 4) drive(seq[i], 3'(i), 1'b0, 1'b1, 1'b1, 4'h0, 4'h0);
            else in_valid = 0;
        end

        // R10: descriptor during config write is dropped
        @(negedge clk);
        cfg_we = 1; cfg_port = 2; cfg_entry = 3; cfg_valid = 0; cfg_label = LD; cfg_vid = 0;
        drive(LA, 3'd2, 0, 1, 1, 4'h0, 4'h0);
        #1 chk(in_ready == 0, "R10 ready low", int'(in_ready), 0);
        @(negedge clk);
        cfg_we = 0; in_valid = 0;
        @(negedge clk);
        chk(out_valid == 0, "R10 dropped", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 0, "R10 dropped+1", int'(out_valid), 0);

        // R11: clearing an entry removes membership
        wr(3, 0, 0, LA, 12'd40);
        one(LA, 3'd5, 1, 1, 1, 4'h0, 4'h0);
        chk(out_ports[3] == 0, "R11 cleared entry", int'(out_ports[3]), 0);
        // R5: duplicate removal on port 1 falls back to entry 3
        wr(1, 2, 0, LA, 12'd12);
        one(LA, 3'd6, 0, 1, 0, 4'h0, 4'h0);
        chk(out_vid[23:12] == 12'd13, "R5 next entry", int'(out_vid[23:12]), 13);
        // R7: strip option changes
        cfg_strip = 4'b0011;
        one(LC, 3'd7, 1, 1, 1, 4'h0, 4'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule